// File: doc/BRIEF.md
# Row-Column Parity Array Corrector

This block protects a 16-bit data word by viewing it as a 4 by 4 grid of bits. Its encoder half produces nine check bits: an even-parity bit for each of the four rows, an even-parity bit for each of the four columns, and one corner bit that covers the whole grid. Its checker half takes a stored or transmitted word with its nine check bits. It recomputes every parity and finds a single flipped data bit where the one failing row meets the one failing column. It repairs that bit and reports any pattern it cannot repair.

Both halves are purely combinational and independent. The encoder is placed on the write side of a storage element and the checker on its read side. No state is kept. The corrected word, a corrected flag and an uncorrectable flag appear in the same cycle as the received word.

Grid mapping: the bit at row i, column j is data bit 4*i+j. Check bit i holds row i, check bit 4+j holds column j, and check bit 8 is the corner.

Top module: `rc_parity_corrector`

## Requirements
- R1: For each row i in 0..3, enc_chk[i] equals the XOR of enc_data[4*i+3:4*i], so that each row together with its check bit has even parity.
- R2: For each column j in 0..3, enc_chk[4+j] equals enc_data[j] ^ enc_data[j+4] ^ enc_data[j+8] ^ enc_data[j+12].
- R3: enc_chk[8] equals the XOR of enc_chk[3:0], which is also the XOR of all sixteen data bits.
- R4: When rx_data and rx_chk form a valid codeword, fix_data equals rx_data and both corrected and uncorrectable are 0.
- R5: When exactly one of the sixteen data bits of a valid codeword is flipped, fix_data equals the original data, corrected is 1 and uncorrectable is 0.
- R6: When exactly one of the nine check bits of a valid codeword is flipped, fix_data equals rx_data unchanged, corrected is 1 and uncorrectable is 0.
- R7: When any two distinct bits among the 25 codeword bits are flipped, uncorrectable is 1, corrected is 0 and fix_data equals rx_data unchanged.
- R8: corrected and uncorrectable are never both 1. Whenever corrected is 1, fix_data differs from rx_data in at most one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enc_data | input | 16 | Data word to be encoded |
| enc_chk | output | 9 | Check bits for enc_data: rows [3:0], columns [7:4], corner [8] |
| rx_data | input | 16 | Received data word |
| rx_chk | input | 9 | Received check bits, same layout as enc_chk |
| fix_data | output | 16 | Received data after repair of a single data-bit error |
| corrected | output | 1 | A single-bit error was found and handled |
| uncorrectable | output | 1 | The check pattern matches no single-bit error |

## Verification
The hardest cases to reach are the double errors that mimic a single error on one axis. One example is a data bit paired with its own row check bit, which leaves only one column failing. Random stimulus almost never produces these, so the bench walks all 300 unordered pairs of the 25 codeword bits on several data words. It also walks every single-bit flip on several words. Random words with zero, one or two injected flips then cover the remaining space.

// File: rtl/rc_parity_corrector.sv
module rc_parity_corrector (
  input  logic [15:0] enc_data,
  output logic [8:0]  enc_chk,
  input  logic [15:0] rx_data,
  input  logic [8:0]  rx_chk,
  output logic [15:0] fix_data,
  output logic        corrected,
  output logic        uncorrectable
);

  localparam int SIDE = 4;

  logic [SIDE-1:0] enc_row, enc_col;
  logic [SIDE-1:0] rx_row, rx_col;
  logic [SIDE-1:0] row_bad, col_bad;
  logic            corner_bad;
  logic            one_row, one_col, no_row, no_col;
  logic            data_hit, chk_hit;
  logic [15:0]     flip;

  for (genvar g = 0; g < SIDE; g++) begin : g_par
    assign enc_row[g] = ^enc_data[SIDE*g +: SIDE];
    assign rx_row[g]  = ^rx_data[SIDE*g +: SIDE];
    assign enc_col[g] = enc_data[g] ^ enc_data[g+SIDE] ^ enc_data[g+2*SIDE] ^ enc_data[g+3*SIDE];
    assign rx_col[g]  = rx_data[g] ^ rx_data[g+SIDE] ^ rx_data[g+2*SIDE] ^ rx_data[g+3*SIDE];
  end

  assign enc_chk = {^enc_row, enc_col, enc_row};

  assign row_bad    = rx_row ^ rx_chk[SIDE-1:0];
  assign col_bad    = rx_col ^ rx_chk[2*SIDE-1:SIDE];
  assign corner_bad = (^rx_data) ^ rx_chk[2*SIDE];

  assign one_row = $onehot(row_bad);
  assign one_col = $onehot(col_bad);
  assign no_row  = (row_bad == '0);
  assign no_col  = (col_bad == '0);

  assign data_hit = one_row && one_col && corner_bad;
  assign chk_hit  = (one_row && no_col && !corner_bad) ||
                    (no_row && one_col && !corner_bad) ||
                    (no_row && no_col && corner_bad);

  for (genvar r = 0; r < SIDE; r++) begin : g_r
    for (genvar c = 0; c < SIDE; c++) begin : g_c
      assign flip[SIDE*r+c] = data_hit & row_bad[r] & col_bad[c];
    end
  end

  assign fix_data      = rx_data ^ flip;
  assign corrected     = data_hit | chk_hit;
  assign uncorrectable = !(no_row && no_col && !corner_bad) && !corrected;

endmodule

// File: rtl/rc_parity_corrector_chk.sv
module rc_parity_corrector_chk (
  input logic [15:0] enc_data,
  input logic [8:0]  enc_chk,
  input logic [15:0] rx_data,
  input logic [8:0]  rx_chk,
  input logic [15:0] fix_data,
  input logic        corrected,
  input logic        uncorrectable
);

  always_comb begin
    if (!$isunknown({rx_data, rx_chk, fix_data, corrected, uncorrectable})) begin
      a_r8_flags_exclusive: assert (!(corrected && uncorrectable));
      a_r8_single_repair: assert (!corrected || ($countones(fix_data ^ rx_data) <= 1));
      a_r7_uncorr_passthru: assert (!uncorrectable || (fix_data == rx_data));
      a_r4_quiet_passthru: assert (corrected || (fix_data == rx_data));
    end
    if (!$isunknown({enc_data, enc_chk})) begin
      a_r3_corner_total: assert (enc_chk[8] == ^enc_data);
    end
  end

endmodule

bind rc_parity_corrector rc_parity_corrector_chk u_chk (
  .enc_data(enc_data), .enc_chk(enc_chk), .rx_data(rx_data), .rx_chk(rx_chk),
  .fix_data(fix_data), .corrected(corrected), .uncorrectable(uncorrectable)
);

// File: tb/rc_parity_corrector_tb.sv
module rc_parity_corrector_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] enc_data = '0;
  logic [8:0]  enc_chk;
  logic [15:0] rx_data = '0;
  logic [8:0]  rx_chk = '0;
  logic [15:0] fix_data;
  logic        corrected, uncorrectable;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  rc_parity_corrector u_dut (
    .enc_data(enc_data), .enc_chk(enc_chk), .rx_data(rx_data), .rx_chk(rx_chk),
    .fix_data(fix_data), .corrected(corrected), .uncorrectable(uncorrectable)
  );

  function automatic logic [8:0] model_enc(input logic [15:0] d);
    logic [3:0] rw, cl;
    for (int i = 0; i < 4; i++) begin
      rw[i] = d[4*i] ^ d[4*i+1] ^ d[4*i+2] ^ d[4*i+3];
      cl[i] = d[i] ^ d[i+4] ^ d[i+8] ^ d[i+12];
    end
    return {rw[0] ^ rw[1] ^ rw[2] ^ rw[3], cl, rw};
  endfunction

  task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] d, input logic [24:0] mask);
    logic [24:0] cw;
    int n;
    string rq;
    cw = {model_enc(d), d} ^ mask;
    n = $countones(mask);
    @(negedge clk);
    enc_data = d;
    rx_data  = cw[15:0];
    rx_chk   = cw[24:16];
    #2;
    expect_eq("R1/R2/R3 enc_chk", {23'd0, enc_chk}, {23'd0, model_enc(d)});
    if (n == 0) begin
      expect_eq("R4 clean", {14'd0, corrected, uncorrectable, fix_data}, {14'd0, 2'b00, d});
    end else if (n == 1) begin
      rq = (mask[15:0] != 0) ? "R5 data flip" : "R6 check flip";
      expect_eq(rq, {14'd0, corrected, uncorrectable, fix_data}, {14'd0, 2'b10, d});
    end else begin
      expect_eq("R7 double", {14'd0, corrected, uncorrectable, fix_data}, {14'd0, 2'b01, cw[15:0]});
    end
    expect_eq("R8 exclusive", {31'd0, corrected & uncorrectable}, 32'd0);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] words [4];
    void'($urandom(32'h5eed_0c0d));
    words[0] = 16'h0000; words[1] = 16'hffff; words[2] = 16'ha5c3; words[3] = 16'h1248;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    expect_eq("R4 reset state", {14'd0, corrected, uncorrectable, fix_data}, 32'd0);
    expect_eq("R1 reset enc", {23'd0, enc_chk}, 32'd0);
    for (int w = 0; w < 4; w++) begin
      apply(words[w], 25'd0);
      for (int b = 0; b < 25; b++) apply(words[w], 25'd1 << b);
    end
    for (int w = 1; w < 4; w++)
      for (int a = 0; a < 25; a++)
        for (int b = a + 1; b < 25; b++)
          apply(words[w], (25'd1 << a) | (25'd1 << b));
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] d;
      int p, q, m;
      d = 16'($urandom);
      m = int'($urandom % 3);
      p = int'($urandom % 25);
      q = (p + 1 + int'($urandom % 24)) % 25;
      if (m == 0) apply(d, 25'd0);
      else if (m == 1) apply(d, 25'd1 << p);
      else apply(d, (25'd1 << p) | (25'd1 << q));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule